// File: doc/BRIEF.md
# Debug Halt and Resume Controller

This block decides when a CPU stops for background debug and when it resumes. It can be asked to stop in three ways: a host BACKGROUND command, a software BGND instruction, or a hardware breakpoint. A stop never lands in the middle of an instruction. The request waits until the CPU signals an instruction boundary. While the CPU is stopped, the register-file write enable comes only from the debug side. The stop lasts until the host sends GO or the block is reset.

The block also holds the bit that picks the serial-side clock: 0 is the constant-frequency source and 1 is the PLL-derived fast source. Whenever that bit takes a new value, a guard counter starts. It counts ticks of the clock that was selected before the change. Until it expires, any SYNC is refused and flagged as an error. A two-bit status word gives the command decoder the current clock choice and the stopped state.

Top module: `dbg_halt_ctl`

## Requirements
- R1: Reset clears `halted`, `stall`, `csel`, `guard_busy`, `sync_ok`, `sync_err` and `status` to 0.
- R2: A BACKGROUND or BGND request while `dbg_en`=1 raises `stall` on the next cycle. `halted` rises only in the cycle after the first `insn_bnd` pulse seen in or after the request cycle.
- R3: Once `halted`=1 it stays 1, whatever `insn_bnd` and new requests do, until a cycle with `host_go`=1. `halted` is 0 in the cycle after that.
- R4: `reg_we` follows `dbg_we` while `halted`=1 and follows `cpu_we` while `halted`=0.
- R5: A breakpoint with `brk_after`=0 halts at the first instruction boundary. With `brk_after`=1 it halts at the second boundary, so one more instruction executes. A boundary in the request cycle counts as the first boundary.
- R6: A BACKGROUND command while `dbg_en`=0 is discarded. `stall` stays 0 and no halt follows.
- R7: A BGND instruction while `dbg_en`=0 holds `stall`=1 from the next cycle until the next `insn_bnd`. No halt follows.
- R8: If `host_go` and a new request arrive in the same cycle while halted, the block resumes first. The request is then pending (`stall`=1) and halts at the next boundary.
- R9: A write of a new value to the clock-select bit updates `csel` on the next cycle and sets `guard_busy`. `guard_busy` clears after GUARD_CYC (default 150) ticks of the previously selected source. `tick_const` belongs to value 0 and `tick_fast` to value 1, and ticks of the new source do not count. A write of the current value has no effect.
- R10: A `sync_req` while `guard_busy`=1, or in the same cycle as a clock-select change, gives a one-cycle `sync_err` pulse on the next cycle and no `sync_ok`. Any other `sync_req` gives `sync_ok` instead.
- R11: `status` is {`csel`, `halted`}: bit 1 is the clock choice and bit 0 the stopped state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbg_en | input | 1 | Debug port enabled |
| insn_bnd | input | 1 | CPU completes an instruction this cycle |
| host_bkgd | input | 1 | Host BACKGROUND command pulse |
| host_go | input | 1 | Host GO command pulse |
| sw_bgnd | input | 1 | CPU is executing a BGND instruction |
| brk_req | input | 1 | Hardware breakpoint request |
| brk_after | input | 1 | Breakpoint type: 1 halts after the next instruction |
| cpu_we | input | 1 | CPU-side register write enable |
| dbg_we | input | 1 | Debug-side register write enable |
| csel_wr | input | 1 | Write strobe for the clock-select bit |
| csel_val | input | 1 | Value written to the clock-select bit |
| tick_const | input | 1 | Tick of the constant-frequency source |
| tick_fast | input | 1 | Tick of the PLL-derived source |
| sync_req | input | 1 | SYNC pulse arrives from the serial side |
| halted | output | 1 | CPU held in debug halt |
| stall | output | 1 | Halt or BGND request waiting for a boundary |
| reg_we | output | 1 | Gated register-file write enable |
| csel | output | 1 | Selected serial clock source |
| guard_busy | output | 1 | Clock-switch guard interval running |
| sync_ok | output | 1 | SYNC accepted (one-cycle pulse) |
| sync_err | output | 1 | SYNC refused during guard (one-cycle pulse) |
| status | output | 2 | {csel, halted} for the command decoder |

## Verification
A cycle-by-cycle vector walk drives the halt logic with each entry source. The before-type and after-type breakpoints are each tried with and without a boundary in the request cycle, which shows whether a same-cycle boundary is counted. Requests made while halted, and GO given together with a request, show that the stopped state ignores boundaries and that GO takes priority. The same requests are repeated with the port disabled, which separates the silent drop of BACKGROUND from the boundary-long stall of BGND. Guard tests tick only the new clock source and then only the old one, stopping one tick short of expiry and then at it. SYNC is sent in the change cycle, during the guard and after it.

// File: rtl/dbg_halt_ctl.sv
module dbg_halt_ctl #(
  parameter int GUARD_CYC = 150,
  localparam int CW = $clog2(GUARD_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dbg_en,
  input  logic       insn_bnd,
  input  logic       host_bkgd,
  input  logic       host_go,
  input  logic       sw_bgnd,
  input  logic       brk_req,
  input  logic       brk_after,
  input  logic       cpu_we,
  input  logic       dbg_we,
  input  logic       csel_wr,
  input  logic       csel_val,
  input  logic       tick_const,
  input  logic       tick_fast,
  input  logic       sync_req,
  output logic       halted,
  output logic       stall,
  output logic       reg_we,
  output logic       csel,
  output logic       guard_busy,
  output logic       sync_ok,
  output logic       sync_err,
  output logic [1:0] status
);

  logic          halt_q, pend_q, skip_q, dead_q;
  logic          csel_q, prev_q, ok_q, err_q;
  logic [CW-1:0] cnt_q;

  wire open_w   = ~halt_q | host_go;
  wire any_req  = host_bkgd | sw_bgnd | brk_req;
  wire new_live = dbg_en & any_req & open_w;
  wire new_aft  = brk_req & brk_after & ~host_bkgd & ~sw_bgnd;
  wire new_dead = ~dbg_en & sw_bgnd & ~halt_q;
  wire req      = pend_q | new_live;
  wire skp      = req & (pend_q ? skip_q : 1'b1) & (new_live ? new_aft : 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
      pend_q <= 1'b0;
      skip_q <= 1'b0;
      dead_q <= 1'b0;
    end else if (halt_q) begin
      if (host_go) begin
        halt_q <= 1'b0;
        pend_q <= new_live;
        skip_q <= new_live & new_aft;
      end
      dead_q <= 1'b0;
    end else if (insn_bnd) begin
      dead_q <= 1'b0;
      skip_q <= 1'b0;
      if (req && !skp) begin
        halt_q <= 1'b1;
        pend_q <= 1'b0;
      end else begin
        pend_q <= req;
      end
    end else begin
      pend_q <= req;
      skip_q <= skp;
      dead_q <= dead_q | new_dead;
    end
  end

  wire chg      = csel_wr & (csel_val != csel_q);
  wire old_tick = prev_q ? tick_fast : tick_const;
  wire busy     = cnt_q != '0;
  wire refuse   = busy | chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csel_q <= 1'b0;
      prev_q <= 1'b0;
      cnt_q  <= '0;
      ok_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (chg) begin
        csel_q <= csel_val;
        prev_q <= csel_q;
        cnt_q  <= CW'(GUARD_CYC);
      end else if (busy && old_tick) begin
        cnt_q <= cnt_q - CW'(1);
      end
      ok_q  <= sync_req & ~refuse;
      err_q <= sync_req & refuse;
    end
  end

  assign halted     = halt_q;
  assign stall      = pend_q | dead_q;
  assign reg_we     = halt_q ? dbg_we : cpu_we;
  assign csel       = csel_q;
  assign guard_busy = busy;
  assign sync_ok    = ok_q;
  assign sync_err   = err_q;
  assign status     = {csel_q, halt_q};

endmodule

// File: rtl/dbg_halt_ctl_chk.sv
module dbg_halt_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dbg_en,
  input logic       insn_bnd,
  input logic       host_go,
  input logic       dbg_we,
  input logic       halted,
  input logic       stall,
  input logic       reg_we,
  input logic       csel,
  input logic       guard_busy,
  input logic       sync_ok,
  input logic       sync_err
);

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !host_go |=> halted); // R3

  AST_GO_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    halted && host_go |=> !halted); // R8

  AST_HALT_AT_BND: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> $past(insn_bnd)); // R2

  AST_GATE_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !dbg_we |-> !reg_we); // R4

  AST_DISABLED_NO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    !halted && !stall && !dbg_en |=> !halted); // R6

  AST_BUSY_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(csel) |-> guard_busy); // R9

  AST_SYNC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_ok && sync_err)); // R10

endmodule

bind dbg_halt_ctl dbg_halt_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .insn_bnd(insn_bnd),
  .host_go(host_go), .dbg_we(dbg_we), .halted(halted), .stall(stall),
  .reg_we(reg_we), .csel(csel), .guard_busy(guard_busy),
  .sync_ok(sync_ok), .sync_err(sync_err)
);

// File: tb/sim_dbg_halt_ctl.sv
module sim_dbg_halt_ctl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_en, insn_bnd, host_bkgd, host_go, sw_bgnd, brk_req, brk_after;
  logic cpu_we, dbg_we, csel_wr, csel_val, tick_const, tick_fast, sync_req;
  logic halted, stall, reg_we, csel, guard_busy, sync_ok, sync_err;
  logic [1:0] status;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dbg_halt_ctl u0 (.*);

  // {en, bkgd, bgnd, brk, after, go, bnd, exp_halted, exp_stall, tag}
  localparam int NV = 25;
  localparam logic [12:0] VEC [NV] = '{
    {9'b1_0000_01_0_0, 4'd2}, {9'b1_1000_00_0_1, 4'd2}, {9'b1_0000_00_0_1, 4'd2},
    {9'b1_0000_01_1_0, 4'd2}, {9'b1_0000_01_1_0, 4'd3}, {9'b1_1000_00_1_0, 4'd3},
    {9'b1_0000_10_0_0, 4'd3}, {9'b1_0010_01_1_0, 4'd5}, {9'b1_0000_10_0_0, 4'd3},
    {9'b1_0011_00_0_1, 4'd5}, {9'b1_0000_01_0_1, 4'd5}, {9'b1_0000_01_1_0, 4'd5},
    {9'b1_1000_10_0_1, 4'd8}, {9'b1_0000_01_1_0, 4'd8}, {9'b1_0000_10_0_0, 4'd3},
    {9'b0_1000_00_0_0, 4'd6}, {9'b0_0100_00_0_1, 4'd7}, {9'b0_0000_00_0_1, 4'd7},
    {9'b0_0000_01_0_0, 4'd7}, {9'b1_0100_00_0_1, 4'd2}, {9'b1_0000_01_1_0, 4'd2},
    {9'b1_0000_10_0_0, 4'd3}, {9'b1_0011_01_0_1, 4'd5}, {9'b1_0000_01_1_0, 4'd5},
    {9'b1_0000_10_0_0, 4'd3}
  };

  function automatic string tag(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd3: return "R3";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    {dbg_en, insn_bnd, host_bkgd, host_go, sw_bgnd, brk_req, brk_after} = 7'b1000000;
    {cpu_we, dbg_we, csel_wr, csel_val, tick_const, tick_fast, sync_req} = 7'b1000000;
  endtask

  initial begin
    idle();
    #22;
    // R1
    chk("R1", "halted", halted, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "csel", csel, 0);
    chk("R1", "guard_busy", guard_busy, 0);
    chk("R1", "sync pulses", {sync_ok, sync_err}, 0);
    chk("R1", "status", status, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {dbg_en, host_bkgd, sw_bgnd, brk_req, brk_after, host_go, insn_bnd} = VEC[i][12:6];
      tick();
      chk(tag(VEC[i][3:0]), $sformatf("halted v%0d", i), halted, VEC[i][5]);
      chk(tag(VEC[i][3:0]), $sformatf("stall v%0d", i), stall, VEC[i][4]);
      chk("R11", $sformatf("status[0] v%0d", i), status[0], VEC[i][5]);
      chk("R4", $sformatf("reg_we v%0d", i), reg_we, !VEC[i][5]);
    end
    idle();

    // R4 while halted, debug writes pass and CPU writes are blocked
    host_bkgd = 1'b1; insn_bnd = 1'b1;
    tick();
    idle();
    chk("R2", "halt on same-cycle boundary", halted, 1);
    cpu_we = 1'b0; dbg_we = 1'b1;
    #1 chk("R4", "dbg write while halted", reg_we, 1);
    cpu_we = 1'b1; dbg_we = 1'b0;
    #1 chk("R4", "cpu write while halted", reg_we, 0);
    host_go = 1'b1;
    tick();
    idle();
    chk("R3", "released by GO", halted, 0);

    // R9 R10 clock switch and guard
    csel_wr = 1'b1; csel_val = 1'b1; sync_req = 1'b1;
    tick();
    csel_wr = 1'b0; sync_req = 1'b0;
    chk("R9", "csel after switch", csel, 1);
    chk("R9", "guard busy", guard_busy, 1);
    chk("R10", "sync in switch cycle refused", {sync_ok, sync_err}, 1);
    chk("R11", "status after switch", status, 2);
    tick_fast = 1'b1;
    for (int k = 0; k < 200; k++) tick();
    tick_fast = 1'b0;
    chk("R9", "new-source ticks ignored", guard_busy, 1);
    sync_req = 1'b1;
    tick();
    sync_req = 1'b0;
    chk("R10", "sync during guard refused", {sync_ok, sync_err}, 1);
    tick_const = 1'b1;
    for (int k = 0; k < 149; k++) tick();
    chk("R9", "busy one tick short", guard_busy, 1);
    tick();
    tick_const = 1'b0;
    chk("R9", "guard expired", guard_busy, 0);
    sync_req = 1'b1;
    tick();
    sync_req = 1'b0;
    chk("R10", "sync accepted", {sync_ok, sync_err}, 2);
    tick();
    chk("R10", "pulse is one cycle", {sync_ok, sync_err}, 0);
    csel_wr = 1'b1; csel_val = 1'b1;
    tick();
    csel_wr = 1'b0;
    chk("R9", "same-value write no guard", guard_busy, 0);
    chk("R9", "same-value write keeps csel", csel, 1);
    csel_wr = 1'b1; csel_val = 1'b0;
    tick();
    csel_wr = 1'b0;
    tick_fast = 1'b1;
    for (int k = 0; k < 150; k++) tick();
    tick_fast = 1'b0;
    chk("R9", "old fast source ends guard", guard_busy, 0);
    chk("R11", "status back to const", status, 0);

    // R1 reset while halted clears everything
    host_bkgd = 1'b1; insn_bnd = 1'b1;
    csel_wr = 1'b1; csel_val = 1'b1;
    tick();
    idle();
    #2 rst_n = 1'b0;
    #1;
    chk("R1", "reset clears halt", halted, 0);
    chk("R1", "reset clears csel and guard", {csel, guard_busy}, 0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule